// File: doc/BRIEF.md
# Ethernet Receive Gating Filter

The block sits between the receive side of a small Ethernet MAC and the logic above it. It decides, one frame at a time, whether a received frame is passed on or discarded. It takes a byte stream with start and end markers from the PHY side, along with the MAC's own transmit stream and transmit-enable. A five-bit control register sets promiscuous reception, acceptance of all group-addressed frames, blocking of frames received while the MAC transmits, internal loopback and full duplex.

Each frame is written into a store-and-forward buffer while its destination address is compared against one programmed station address. Transmit activity during the frame is also tracked. On the end marker the frame is either committed and later streamed out whole, or rolled back so that no byte of it ever leaves the block. A one-cycle status pulse reports the decision for every frame. In loopback the transmit stream takes the place of the PHY receive stream, and the PHY transmit outputs are held at zero.

Top module: `rx_gate_filter`

## Requirements
- R1: The control register loads `cfg_*_i` only on a cycle with `cfg_we_i` high. Its reset value has promiscuous set and all other controls clear, so after reset a unicast frame to any address is accepted.
- R2: With promiscuous set, every frame of at least 6 bytes is accepted whatever its destination.
- R3: With promiscuous clear, a unicast frame is accepted only if its first 6 bytes equal the station address. The first byte on the stream is compared with `station_addr_i[47:40]` and the sixth with `station_addr_i[7:0]`.
- R4: A destination is group-addressed when bit 0 of its first byte is 1. With promiscuous clear, such a frame is accepted when pass-all-group is set and dropped when it is clear, unless R5 applies.
- R5: A destination of six bytes of 8'hFF is always accepted.
- R6: With receive-own blocking set and full duplex clear, a frame is dropped if transmit-enable is high in any cycle from its start beat through its end beat.
- R7: Transmit-enable has no effect on acceptance when receive-own blocking is clear or full duplex is set.
- R8: With loopback set, the transmit stream is the receive source, the PHY receive stream is ignored, and `phy_tx_valid_o`, `phy_tx_en_o` and `phy_tx_data_o` are zero. With loopback clear, those outputs equal `tx_valid_i`, `tx_en_i` and `tx_data_i`.
- R9: `frame_done_o` is high for exactly the cycle after each end beat of a started frame, and `frame_accept_o` carries the decision in that cycle.
- R10: A dropped frame produces no output beat. An accepted frame is emitted byte for byte in order, with `out_sof_o` on the first beat and `out_eof_o` on the last.
- R11: A frame shorter than 6 bytes is dropped, even in promiscuous mode.
- R12: A frame longer than DEPTH bytes is dropped. A frame of exactly DEPTH bytes fits when the buffer is empty.
- R13: Valid beats without a start marker outside a frame are ignored. They produce neither status nor output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Control register load strobe |
| cfg_promisc_i | input | 1 | Promiscuous reception |
| cfg_mcast_i | input | 1 | Pass all group-addressed frames |
| cfg_own_blk_i | input | 1 | Block frames received during transmit |
| cfg_loop_i | input | 1 | Internal loopback |
| cfg_fdx_i | input | 1 | Full duplex |
| station_addr_i | input | 48 | Station address, first byte in bits 47:40 |
| rx_valid_i | input | 1 | PHY receive beat valid |
| rx_data_i | input | 8 | PHY receive byte |
| rx_sof_i | input | 1 | PHY receive first beat of frame |
| rx_eof_i | input | 1 | PHY receive last beat of frame |
| tx_valid_i | input | 1 | Transmit beat valid |
| tx_data_i | input | 8 | Transmit byte |
| tx_sof_i | input | 1 | Transmit first beat of frame |
| tx_eof_i | input | 1 | Transmit last beat of frame |
| tx_en_i | input | 1 | Transmit enable |
| phy_tx_valid_o | output | 1 | Beat valid toward PHY |
| phy_tx_data_o | output | 8 | Byte toward PHY |
| phy_tx_en_o | output | 1 | Transmit enable toward PHY |
| out_valid_o | output | 1 | Filtered beat valid |
| out_data_o | output | 8 | Filtered byte |
| out_sof_o | output | 1 | Filtered first beat |
| out_eof_o | output | 1 | Filtered last beat |
| frame_done_o | output | 1 | Per-frame decision strobe |
| frame_accept_o | output | 1 | Decision: 1 accept, 0 drop |

## Verification
Several internal faults show up on the status strobe one cycle after the end beat: a stuck or stale address-match flag, a lost transmit-overlap flag, or a wrong byte index. Each appears as an accept where a drop was due, or the reverse. A wrong commit or rollback pointer shows within a few cycles after that. It appears as bytes of a dropped frame on the output, a missing or shifted byte, or misplaced start and end markers. A fault in the control register or the loopback select appears on the PHY transmit outputs in the same cycle as the stimulus.

// File: rtl/rx_gate_pkg.sv
`timescale 1ns/1ps
package rx_gate_pkg;
  typedef struct packed {
    logic promisc;
    logic mcast;
    logic own_blk;
    logic loop;
    logic fdx;
  } gate_cfg_t;

  typedef struct packed {
    logic       valid;
    logic       sof;
    logic       eof;
    logic [7:0] data;
  } beat_t;

  localparam gate_cfg_t CFG_RESET = '{promisc: 1'b1, mcast: 1'b0, own_blk: 1'b0,
                                      loop: 1'b0, fdx: 1'b0};
  localparam logic [7:0] BCAST_BYTE = 8'hFF;
endpackage

// File: rtl/rx_gate_cfg.sv
`timescale 1ns/1ps
module rx_gate_cfg
  import rx_gate_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      we_i,
  input  gate_cfg_t cfg_i,
  output gate_cfg_t cfg_o
);
  gate_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= CFG_RESET;
    else if (we_i) cfg_q <= cfg_i;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/rx_src_mux.sv
`timescale 1ns/1ps
module rx_src_mux
  import rx_gate_pkg::*;
(
  input  logic       loop_i,
  input  beat_t      phy_rx_i,
  input  beat_t      tx_i,
  input  logic       tx_en_i,
  output beat_t      sel_o,
  output logic       phy_tx_valid_o,
  output logic [7:0] phy_tx_data_o,
  output logic       phy_tx_en_o
);
  always_comb begin
    sel_o          = loop_i ? tx_i : phy_rx_i;
    phy_tx_valid_o = tx_i.valid & ~loop_i;
    phy_tx_data_o  = loop_i ? 8'h00 : tx_i.data;
    phy_tx_en_o    = tx_en_i & ~loop_i;
  end
endmodule

// File: rtl/rx_addr_match.sv
`timescale 1ns/1ps
module rx_addr_match
  import rx_gate_pkg::*;
#(
  parameter int ADDR_BYTES = 6
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  gate_cfg_t               cfg_i,
  input  logic [ADDR_BYTES*8-1:0] station_i,
  input  beat_t                   beat_i,
  input  logic                    tx_en_i,
  output logic                    start_o,
  output logic                    active_o,
  output logic                    last_o,
  output logic                    keep_o
);
  localparam int IW = $clog2(ADDR_BYTES + 1);

  logic [7:0] st_bytes [ADDR_BYTES];
  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_st
    assign st_bytes[g] = station_i[(ADDR_BYTES-1-g)*8 +: 8];
  end

  logic          in_frame_q, uc_q, bc_q, mc_q, own_q;
  logic [IW-1:0] idx_q;

  logic          start, cont, active;
  logic [IW-1:0] idx_cur, idx_sel, idx_n;
  logic          in_addr, len_ok, own_hit;
  logic          uc_n, bc_n, mc_n, own_n;
  logic [7:0]    st_cur;

  always_comb begin
    start   = beat_i.valid & beat_i.sof;
    cont    = beat_i.valid & ~beat_i.sof & in_frame_q;
    active  = start | cont;
    idx_cur = start ? '0 : idx_q;
    in_addr = idx_cur < IW'(ADDR_BYTES);
    idx_sel = in_addr ? idx_cur : '0;
    st_cur  = st_bytes[idx_sel];
    idx_n   = (idx_cur == IW'(ADDR_BYTES)) ? idx_cur : idx_cur + 1'b1;
    len_ok  = idx_cur >= IW'(ADDR_BYTES - 1);
    own_hit = cfg_i.own_blk & ~cfg_i.fdx & tx_en_i;

    uc_n  = (start | uc_q) & (~in_addr | (beat_i.data == st_cur));
    bc_n  = (start | bc_q) & (~in_addr | (beat_i.data == BCAST_BYTE));
    mc_n  = (idx_cur == '0) ? beat_i.data[0] : mc_q;
    own_n = (~start & own_q) | own_hit;

    keep_o = len_ok & ~own_n &
             (cfg_i.promisc | bc_n | (cfg_i.mcast & mc_n) | uc_n);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q <= 1'b0;
      idx_q      <= '0;
      uc_q       <= 1'b0;
      bc_q       <= 1'b0;
      mc_q       <= 1'b0;
      own_q      <= 1'b0;
    end else if (active) begin
      in_frame_q <= ~beat_i.eof;
      idx_q      <= idx_n;
      uc_q       <= uc_n;
      bc_q       <= bc_n;
      mc_q       <= mc_n;
      own_q      <= own_n;
    end else if (in_frame_q) begin
      own_q      <= own_q | own_hit;  // transmit during gaps inside a frame
    end
  end

  assign start_o  = start;
  assign active_o = active;
  assign last_o   = active & beat_i.eof;
endmodule

// File: rtl/rx_frame_store.sv
`timescale 1ns/1ps
module rx_frame_store #(
  parameter int DEPTH = 64  // power of two
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic       wr_sof_i,
  input  logic       wr_eof_i,
  input  logic [7:0] wr_data_i,
  input  logic       keep_i,
  output logic       ovf_o,
  output logic       out_valid_o,
  output logic [7:0] out_data_o,
  output logic       out_sof_o,
  output logic       out_eof_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [9:0]    mem [DEPTH];
  logic [PW-1:0] wr_q, cmt_q, rd_q;
  logic          ovf_q;

  logic [PW-1:0] base, occ;
  logic          full, ovf_n, commit;

  always_comb begin
    base   = wr_sof_i ? cmt_q : wr_q;  // a start beat discards any open frame
    occ    = base - rd_q;
    full   = occ == PW'(DEPTH);
    ovf_n  = (~wr_sof_i & ovf_q) | (wr_en_i & full);
    commit = wr_en_i & wr_eof_i & keep_i & ~ovf_n;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i && !ovf_n) mem[base[AW-1:0]] <= {wr_sof_i, wr_eof_i, wr_data_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      cmt_q <= '0;
      ovf_q <= 1'b0;
    end else if (wr_en_i) begin
      ovf_q <= ovf_n;
      if (wr_eof_i) begin
        if (commit) begin
          cmt_q <= base + 1'b1;
          wr_q  <= base + 1'b1;
        end else begin
          wr_q  <= cmt_q;
        end
      end else if (!ovf_n) begin
        wr_q <= base + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q        <= '0;
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
      out_sof_o   <= 1'b0;
      out_eof_o   <= 1'b0;
    end else if (rd_q != cmt_q) begin
      out_valid_o <= 1'b1;
      {out_sof_o, out_eof_o, out_data_o} <= mem[rd_q[AW-1:0]];
      rd_q        <= rd_q + 1'b1;
    end else begin
      out_valid_o <= 1'b0;
      out_sof_o   <= 1'b0;
      out_eof_o   <= 1'b0;
    end
  end

  assign ovf_o = ovf_n;
endmodule

// File: rtl/rx_gate_filter.sv
`timescale 1ns/1ps
module rx_gate_filter
  import rx_gate_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int DEPTH      = 64
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cfg_we_i,
  input  logic        cfg_promisc_i,
  input  logic        cfg_mcast_i,
  input  logic        cfg_own_blk_i,
  input  logic        cfg_loop_i,
  input  logic        cfg_fdx_i,
  input  logic [47:0] station_addr_i,
  input  logic        rx_valid_i,
  input  logic [7:0]  rx_data_i,
  input  logic        rx_sof_i,
  input  logic        rx_eof_i,
  input  logic        tx_valid_i,
  input  logic [7:0]  tx_data_i,
  input  logic        tx_sof_i,
  input  logic        tx_eof_i,
  input  logic        tx_en_i,
  output logic        phy_tx_valid_o,
  output logic [7:0]  phy_tx_data_o,
  output logic        phy_tx_en_o,
  output logic        out_valid_o,
  output logic [7:0]  out_data_o,
  output logic        out_sof_o,
  output logic        out_eof_o,
  output logic        frame_done_o,
  output logic        frame_accept_o
);
  gate_cfg_t cfg_d, cfg_q;
  beat_t     phy_rx, tx_beat, sel_beat;
  logic      m_start, m_active, m_last, m_keep, s_ovf;
  logic      done_q, acc_q;

  assign cfg_d   = '{promisc: cfg_promisc_i, mcast: cfg_mcast_i, own_blk: cfg_own_blk_i,
                     loop: cfg_loop_i, fdx: cfg_fdx_i};
  assign phy_rx  = '{valid: rx_valid_i, sof: rx_sof_i, eof: rx_eof_i, data: rx_data_i};
  assign tx_beat = '{valid: tx_valid_i, sof: tx_sof_i, eof: tx_eof_i, data: tx_data_i};

  rx_gate_cfg u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .cfg_i  (cfg_d),
    .cfg_o  (cfg_q)
  );

  rx_src_mux u_mux (
    .loop_i         (cfg_q.loop),
    .phy_rx_i       (phy_rx),
    .tx_i           (tx_beat),
    .tx_en_i        (tx_en_i),
    .sel_o          (sel_beat),
    .phy_tx_valid_o (phy_tx_valid_o),
    .phy_tx_data_o  (phy_tx_data_o),
    .phy_tx_en_o    (phy_tx_en_o)
  );

  rx_addr_match #(.ADDR_BYTES(ADDR_BYTES)) u_match (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cfg_i     (cfg_q),
    .station_i (station_addr_i[ADDR_BYTES*8-1:0]),
    .beat_i    (sel_beat),
    .tx_en_i   (tx_en_i),
    .start_o   (m_start),
    .active_o  (m_active),
    .last_o    (m_last),
    .keep_o    (m_keep)
  );

  rx_frame_store #(.DEPTH(DEPTH)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (m_active),
    .wr_sof_i    (m_start),
    .wr_eof_i    (m_last),
    .wr_data_i   (sel_beat.data),
    .keep_i      (m_keep),
    .ovf_o       (s_ovf),
    .out_valid_o (out_valid_o),
    .out_data_o  (out_data_o),
    .out_sof_o   (out_sof_o),
    .out_eof_o   (out_eof_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      acc_q  <= 1'b0;
    end else begin
      done_q <= m_last;
      acc_q  <= m_last & m_keep & ~s_ovf;
    end
  end

  assign frame_done_o   = done_q;
  assign frame_accept_o = acc_q;
endmodule

// File: rtl/rx_gate_filter_chk.sv
`timescale 1ns/1ps
module rx_gate_filter_chk
  import rx_gate_pkg::*;
(
  input logic      clk_i,
  input logic      rst_ni,
  input gate_cfg_t cfg_i,
  input logic      sel_valid_i,
  input logic      sel_sof_i,
  input logic      sel_eof_i,
  input logic      tx_en_i,
  input logic      phy_tx_valid_i,
  input logic      phy_tx_en_i,
  input logic      out_valid_i,
  input logic      out_sof_i,
  input logic      out_eof_i,
  input logic      frame_done_i,
  input logic      frame_accept_i
);
  logic       in_f_q, hit_q, out_in_q;
  logic [2:0] cnt_q;
  logic       start, last, hit_n;
  logic [2:0] cnt_cur;

  always_comb begin
    start   = sel_valid_i & sel_sof_i;
    last    = sel_valid_i & sel_eof_i & (sel_sof_i | in_f_q);
    cnt_cur = start ? 3'd0 : cnt_q;
    hit_n   = (~start & hit_q) | (cfg_i.own_blk & ~cfg_i.fdx & tx_en_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_f_q   <= 1'b0;
      hit_q    <= 1'b0;
      cnt_q    <= '0;
      out_in_q <= 1'b0;
    end else begin
      if (start || (sel_valid_i && in_f_q)) begin
        in_f_q <= ~sel_eof_i;
        hit_q  <= hit_n;
        cnt_q  <= (cnt_cur == 3'd6) ? cnt_cur : cnt_cur + 3'd1;
      end else if (in_f_q) begin
        hit_q  <= hit_n;
      end
      if (out_valid_i) out_in_q <= ~out_eof_i;
    end
  end

  // R9
  accept_needs_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_accept_i |-> frame_done_i);
  // R9
  done_after_eof_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last |=> frame_done_i);
  // R6
  own_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last && hit_n) |=> !frame_accept_i);
  // R11
  runt_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last && cnt_cur < 3'd5) |=> !frame_accept_i);
  // R8
  loop_tx_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_i.loop |-> (!phy_tx_valid_i && !phy_tx_en_i));
  // R10
  out_mark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_sof_i || out_eof_i) |-> out_valid_i);
  // R10
  out_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_i |-> (out_sof_i != out_in_q));
endmodule

bind rx_gate_filter rx_gate_filter_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cfg_i          (cfg_q),
  .sel_valid_i    (sel_beat.valid),
  .sel_sof_i      (sel_beat.sof),
  .sel_eof_i      (sel_beat.eof),
  .tx_en_i        (tx_en_i),
  .phy_tx_valid_i (phy_tx_valid_o),
  .phy_tx_en_i    (phy_tx_en_o),
  .out_valid_i    (out_valid_o),
  .out_sof_i      (out_sof_o),
  .out_eof_i      (out_eof_o),
  .frame_done_i   (frame_done_o),
  .frame_accept_i (frame_accept_o)
);

// File: tb/rx_gate_filter_tb.sv
`timescale 1ns/1ps
module rx_gate_filter_tb;
  localparam int DEPTH = 64;
  localparam logic [47:0] STATION = 48'h02_11_22_33_44_55;
  localparam logic [47:0] OTHER   = 48'h02_11_22_33_44_56;
  localparam logic [47:0] GROUP   = 48'h01_00_5E_00_00_01;
  // {promisc, mcast, own_blk, loop, fdx, dsel[1:0], txen, exp, len[6:0]}
  // dsel: 0 station, 1 other unicast, 2 group, 3 broadcast
  localparam int NV = 15;
  localparam logic [15:0] VECS [NV] = '{
    16'b1_0_0_0_0_01_0_1_0001010,
    16'b0_0_0_0_0_00_0_1_0001010,
    16'b0_0_0_0_0_01_0_0_0001010,
    16'b0_0_0_0_0_10_0_0_0001100,
    16'b0_1_0_0_0_10_0_1_0001100,
    16'b0_0_0_0_0_11_0_1_0001000,
    16'b0_1_0_0_0_01_0_0_0001010,
    16'b1_0_1_0_0_01_1_0_0001010,
    16'b1_0_0_0_0_01_1_1_0001010,
    16'b1_0_1_0_1_01_1_1_0001010,
    16'b1_0_0_1_0_00_1_1_0001001,
    16'b1_0_1_1_0_00_1_0_0001001,
    16'b0_0_0_0_0_00_0_1_0000110,
    16'b1_0_0_0_0_01_0_0_0000101,
    16'b0_0_1_0_0_00_0_1_0001011
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, c_p = 0, c_m = 0, c_o = 0, c_l = 0, c_f = 0;
  logic rx_valid = 0, rx_sof = 0, rx_eof = 0, tx_valid = 0, tx_sof = 0, tx_eof = 0, tx_en = 0;
  logic [7:0] rx_data = 0, tx_data = 0;
  logic phy_tx_valid, phy_tx_en, out_valid, out_sof, out_eof, frame_done, frame_accept;
  logic [7:0] phy_tx_data, out_data;

  int n_chk = 0, n_bad = 0;
  int done_cnt = 0, ocnt = 0;
  logic last_acc = 0, done_next = 0;
  logic [7:0] obuf [128];
  logic osof [128];
  logic oeof [128];

  always #2.5 clk = ~clk;

  rx_gate_filter #(.DEPTH(DEPTH)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we),
    .cfg_promisc_i(c_p), .cfg_mcast_i(c_m), .cfg_own_blk_i(c_o), .cfg_loop_i(c_l), .cfg_fdx_i(c_f),
    .station_addr_i(STATION),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_sof_i(rx_sof), .rx_eof_i(rx_eof),
    .tx_valid_i(tx_valid), .tx_data_i(tx_data), .tx_sof_i(tx_sof), .tx_eof_i(tx_eof), .tx_en_i(tx_en),
    .phy_tx_valid_o(phy_tx_valid), .phy_tx_data_o(phy_tx_data), .phy_tx_en_o(phy_tx_en),
    .out_valid_o(out_valid), .out_data_o(out_data), .out_sof_o(out_sof), .out_eof_o(out_eof),
    .frame_done_o(frame_done), .frame_accept_o(frame_accept)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (frame_done) begin
        done_cnt = done_cnt + 1;
        last_acc = frame_accept;
      end
      if (out_valid && ocnt < 128) begin
        obuf[ocnt] = out_data;
        osof[ocnt] = out_sof;
        oeof[ocnt] = out_eof;
        ocnt = ocnt + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] fbyte(input logic [1:0] dsel, input int i);
    logic [47:0] a;
    case (dsel)
      2'd0: a = STATION;
      2'd1: a = OTHER;
      2'd2: a = GROUP;
      default: a = '1;
    endcase
    if (i < 6) return a[47-8*i -: 8];
    return 8'hA0 + 8'(i);
  endfunction

  function automatic string vtag(input int k);
    case (k)
      0: return "R2";
      1, 2: return "R3";
      3, 4, 6: return "R4";
      5: return "R5";
      7, 11: return "R6";
      8, 9, 14: return "R7";
      10: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic set_cfg(input bit p, input bit m, input bit o, input bit l, input bit f);
    @(negedge clk);
    {c_p, c_m, c_o, c_l, c_f} = {p, m, o, l, f};
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send(input bit loop, input logic [1:0] dsel, input int len,
                      input bit txen, input bit use_sof);
    int errs = 0;
    done_cnt = 0;
    ocnt = 0;
    for (int i = 0; i < len; i++) begin
      logic [7:0] b;
      logic s, e;
      @(negedge clk);
      b = fbyte(dsel, i);
      s = use_sof && (i == 0);
      e = (i == len - 1);
      if (loop) begin
        {tx_valid, tx_data, tx_sof, tx_eof, tx_en} = {1'b1, b, s, e, 1'b1};
        {rx_valid, rx_data, rx_sof, rx_eof} = {1'b1, ~b, s, e};
      end else begin
        {rx_valid, rx_data, rx_sof, rx_eof} = {1'b1, b, s, e};
        {tx_valid, tx_data, tx_sof, tx_eof} = {1'b1, 8'h5A ^ 8'(i), 1'b0, 1'b0};
        tx_en = txen && (i == 3);
      end
      #1;
      if (loop) begin
        if (phy_tx_valid || phy_tx_en || phy_tx_data != 8'h00) errs++;
      end else begin
        if (phy_tx_valid != tx_valid || phy_tx_en != tx_en || phy_tx_data != tx_data) errs++;
      end
    end
    @(negedge clk);
    {rx_valid, rx_sof, rx_eof, tx_valid, tx_sof, tx_eof, tx_en} = '0;
    rx_data = 8'h00;
    tx_data = 8'h00;
    done_next = frame_done;
    check(errs == 0, "R8 phy transmit outputs", errs, 0);
  endtask

  task automatic expect_frame(input string req, input bit exp, input logic [1:0] dsel,
                              input int len);
    int bad = 0;
    repeat (len + 10) @(negedge clk);
    check(done_next == 1'b1, "R9 strobe one cycle after end beat", int'(done_next), 1);
    check(done_cnt == 1, "R9 one strobe per frame", done_cnt, 1);
    check(last_acc == exp, req, int'(last_acc), int'(exp));
    check(ocnt == (exp ? len : 0), "R10 output beat count", ocnt, exp ? len : 0);
    if (exp && ocnt == len) begin
      for (int i = 0; i < len; i++) begin
        if (obuf[i] != fbyte(dsel, i) || osof[i] != (i == 0) || oeof[i] != (i == len - 1)) bad++;
      end
      check(bad == 0, "R10 output bytes and markers", bad, 0);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && !frame_done && !frame_accept, "R9 reset outputs idle",
          int'(out_valid | frame_done | frame_accept), 0);

    // R1 reset value: promiscuous, other address accepted
    send(1'b0, 2'd1, 10, 1'b0, 1'b1);
    expect_frame("R1 reset promiscuous", 1'b1, 2'd1, 10);

    // R1 inputs without load strobe have no effect
    @(negedge clk);
    {c_p, c_m, c_o, c_l, c_f} = 5'b0;
    send(1'b0, 2'd1, 10, 1'b0, 1'b1);
    expect_frame("R1 no load without strobe", 1'b1, 2'd1, 10);

    for (int k = 0; k < NV; k++) begin
      logic [15:0] v;
      v = VECS[k];
      set_cfg(v[15], v[14], v[13], v[12], v[11]);
      send(v[12], v[10:9], int'(v[6:0]), v[8], 1'b1);
      expect_frame(vtag(k), v[7], v[10:9], int'(v[6:0]));
    end

    // R12 buffer limit
    set_cfg(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    send(1'b0, 2'd1, DEPTH + 1, 1'b0, 1'b1);
    expect_frame("R12 oversize dropped", 1'b0, 2'd1, DEPTH + 1);
    send(1'b0, 2'd1, DEPTH, 1'b0, 1'b1);
    expect_frame("R12 full size kept", 1'b1, 2'd1, DEPTH);

    // R13 beats without a start marker
    send(1'b0, 2'd1, 8, 1'b0, 1'b0);
    repeat (18) @(negedge clk);
    check(done_cnt == 0, "R13 no status", done_cnt, 0);
    check(ocnt == 0, "R13 no output", ocnt, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule